// File: doc/BRIEF.md
# Software Write-Lock Sequence Guard

This block sits beside the page loader of a byte-wide, page-programmed nonvolatile memory. It observes every byte write (a 17-bit address and one data byte per lane) and recognizes fixed address/data command sequences. One sequence opens the current page for writing and arms a software lock. A longer sequence removes the lock. Each byte lane keeps its own lock bit, so any mix of locked and open lanes is possible.

A lock change never takes effect immediately. It is held as pending in the lane's sequence state and applied when the programming cycle that follows ends (the `prog_end` pulse), whether or not any data bytes were loaded after the command. For every byte, the guard reports whether it was a command byte that must not reach the page buffer. For the page being loaded, it reports whether the commit may actually store data. The lock bit is not cleared by `rst` and starts at zero, the state in which a fresh device is delivered.

Top module: `wp_seq_guard`

## Requirements
- R1: `wp_on` is 0 for every lane at start-up, and asserting `rst` never changes it.
- R2: The arm sequence is the three writes 0xAA to 0x05555, 0x55 to 0x02AAA and 0xA0 to 0x05555, given as the first bytes of a page. Each of these bytes raises that lane's `cmd_byte` in the cycle after its strobe. That lane's `wp_on` rises in the cycle after the next `prog_end` pulse, even if no data byte followed.
- R3: The release sequence is the six writes 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555. Each byte is flagged as a command, bytes after it are permitted, and `wp_on` falls in the cycle after the next `prog_end`.
- R4: `wp_on` of a lane changes only in the cycle after a `prog_end` pulse on that lane.
- R5: While a lane is locked, `page_ok` is 0 for a page loaded without the arm sequence, and 1 once the arm sequence has been recognized for that page.
- R6: While a lane is unlocked, `page_ok` stays 1 for ordinary data writes.
- R7: A byte that does not continue a partial sequence returns the matcher to idle and is treated as data (`cmd_byte` 0).
- R8: A sequence is recognized only as the leading bytes of a page. After any data byte has been loaded, 0xAA@0x05555 is data until the next `prog_end`.
- R9: Each lane has its own matcher and lock bit (lane i uses `wr_stb[i]`, `wr_data[8i+7:8i]`, `prog_end[i]`). Lanes do not influence each other.
- R10: A strobe in the same cycle as that lane's `prog_end` is ignored.
- R11: In the cycle after `prog_end`, `page_ok` of that lane equals the inverse of its new `wp_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the matchers (not of the lock bits) |
| wr_stb | input | NBLK | Byte write strobe per lane |
| wr_addr | input | ADDR_W | Byte address shared by all lanes |
| wr_data | input | NBLK*8 | Write data, one byte per lane |
| prog_end | input | NBLK | End-of-programming pulse per lane |
| wp_on | output | NBLK | Software lock state per lane |
| page_ok | output | NBLK | The loaded page may be stored on commit |
| cmd_byte | output | NBLK | The previous strobed byte was a command byte, not page data |

## Verification
A wrong sequence state shows on `cmd_byte` one cycle after the offending strobe, because a following sequence byte is then flagged or left unflagged incorrectly. It also shows on `page_ok` in that same cycle. A wrongly applied or missed lock change shows on `wp_on` and `page_ok` one cycle after `prog_end`, and it stays visible through every later page. The bench therefore checks `cmd_byte` after every strobe and checks both level outputs around each end-of-programming pulse, including pulses that coincide with a strobe and pulses that follow a broken sequence.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] B_LEAD  = 8'hAA;
  localparam logic [BYTE_W-1:0] B_PAIR  = 8'h55;
  localparam logic [BYTE_W-1:0] B_LOCK  = 8'hA0;
  localparam logic [BYTE_W-1:0] B_ERASE = 8'h80;
  localparam logic [BYTE_W-1:0] B_FREE  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_D3,
    ST_D4,
    ST_D5,
    ST_OPEN_EN,
    ST_OPEN_DIS
  } seq_t;
endpackage

// File: rtl/wpg_step.sv
module wpg_step
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_HI = 'h05555,
  parameter logic [ADDR_W-1:0] KEY_LO = 'h02AAA
) (
  input  seq_t              st,
  input  logic              dirty,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  output seq_t              st_n,
  output logic              is_cmd
);
  logic at_hi, at_lo;

  assign at_hi = (addr == KEY_HI);
  assign at_lo = (addr == KEY_LO);

  always_comb begin
    st_n   = ST_IDLE;
    is_cmd = 1'b0;
    case (st)
      ST_IDLE: if (!dirty && at_hi && data == B_LEAD) begin
        st_n = ST_K1; is_cmd = 1'b1;
      end
      ST_K1: if (at_lo && data == B_PAIR) begin
        st_n = ST_K2; is_cmd = 1'b1;
      end
      ST_K2: begin
        if (at_hi && data == B_LOCK) begin
          st_n = ST_OPEN_EN; is_cmd = 1'b1;
        end else if (at_hi && data == B_ERASE) begin
          st_n = ST_D3; is_cmd = 1'b1;
        end
      end
      ST_D3: if (at_hi && data == B_LEAD) begin
        st_n = ST_D4; is_cmd = 1'b1;
      end
      ST_D4: if (at_lo && data == B_PAIR) begin
        st_n = ST_D5; is_cmd = 1'b1;
      end
      ST_D5: if (at_hi && data == B_FREE) begin
        st_n = ST_OPEN_DIS; is_cmd = 1'b1;
      end
      ST_OPEN_EN:  st_n = ST_OPEN_EN;
      ST_OPEN_DIS: st_n = ST_OPEN_DIS;
      default:     st_n = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wpg_lane.sv
module wpg_lane
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_HI = 'h05555,
  parameter logic [ADDR_W-1:0] KEY_LO = 'h02AAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] data,
  input  logic              prog_end,
  output logic              wp_on,
  output logic              page_ok,
  output logic              cmd_byte
);
  seq_t st_q, st_n;
  logic dirty_q, is_cmd, open_n;
  logic prot_q   = 1'b0;
  logic permit_q = 1'b1;
  logic cmd_q;

  wpg_step #(.ADDR_W(ADDR_W), .KEY_HI(KEY_HI), .KEY_LO(KEY_LO)) u_step (
    .st(st_q), .dirty(dirty_q), .addr(addr), .data(data),
    .st_n(st_n), .is_cmd(is_cmd)
  );

  assign open_n = (st_n == ST_OPEN_EN) || (st_n == ST_OPEN_DIS);

  // Lock bit models nonvolatile storage: no reset branch.
  always_ff @(posedge clk) begin
    if (!rst && prog_end) begin
      if (st_q == ST_OPEN_EN)       prot_q <= 1'b1;
      else if (st_q == ST_OPEN_DIS) prot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dirty_q  <= 1'b0;
      cmd_q    <= 1'b0;
      permit_q <= !prot_q;
    end else if (prog_end) begin
      st_q     <= ST_IDLE;
      dirty_q  <= 1'b0;
      cmd_q    <= 1'b0;
      if (st_q == ST_OPEN_EN)       permit_q <= 1'b0;
      else if (st_q == ST_OPEN_DIS) permit_q <= 1'b1;
      else                          permit_q <= !prot_q;
    end else if (stb) begin
      st_q     <= st_n;
      dirty_q  <= dirty_q | !is_cmd;
      cmd_q    <= is_cmd;
      permit_q <= !prot_q | open_n;
    end else begin
      cmd_q    <= 1'b0;
    end
  end

  assign wp_on    = prot_q;
  assign page_ok  = permit_q;
  assign cmd_byte = cmd_q;

  assert_wp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(prog_end) |-> $stable(prot_q));

  assert_cmd_src_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_q |-> ($past(stb) && !$past(prog_end)));

  assert_collide_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(prog_end) && $past(stb)) |-> !cmd_q);

  assert_close_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(prog_end) && !$past(rst)) |-> (permit_q == !prot_q));

  assert_dirty_R8: assert property (@(posedge clk) disable iff (rst)
    (stb && !prog_end && st_q == ST_IDLE && dirty_q) |=> !cmd_q);
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wpg_pkg::*;
#(
  parameter int NBLK   = 4,
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_HI = 17'h05555,
  parameter logic [ADDR_W-1:0] KEY_LO = 17'h02AAA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBLK-1:0]        wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [NBLK*BYTE_W-1:0] wr_data,
  input  logic [NBLK-1:0]        prog_end,
  output logic [NBLK-1:0]        wp_on,
  output logic [NBLK-1:0]        page_ok,
  output logic [NBLK-1:0]        cmd_byte
);
  localparam int DATA_W = NBLK * BYTE_W;

  for (genvar g = 0; g < NBLK; g++) begin : g_lane
    wpg_lane #(.ADDR_W(ADDR_W), .KEY_HI(KEY_HI), .KEY_LO(KEY_LO)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .stb      (wr_stb[g]),
      .addr     (wr_addr),
      .data     (wr_data[g*BYTE_W +: BYTE_W]),
      .prog_end (prog_end[g]),
      .wp_on    (wp_on[g]),
      .page_ok  (page_ok[g]),
      .cmd_byte (cmd_byte[g])
    );
  end

  initial begin
    if (DATA_W != $bits(wr_data)) $error("data width mismatch");
  end
endmodule

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;
  localparam int N = 4;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [N-1:0]  wr_stb = '0;
  logic [16:0]   wr_addr = '0;
  logic [N*8-1:0] wr_data = '0;
  logic [N-1:0]  prog_end = '0;
  logic [N-1:0]  wp_on, page_ok, cmd_byte;
  int total = 0, bad = 0;
  bit done = 0;

  wp_seq_guard u0 (.clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_end(prog_end), .wp_on(wp_on), .page_ok(page_ok),
    .cmd_byte(cmd_byte));

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {4{b}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] m, input logic [16:0] a, input logic [31:0] d,
                     input logic [3:0] ecmd, input string req);
    @(negedge clk); wr_stb = m; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    chk(req, {28'd0, cmd_byte}, {28'd0, ecmd});
    @(negedge clk); wr_stb = '0;
  endtask

  task automatic pend(input logic [3:0] m);
    @(negedge clk); prog_end = m;
    @(posedge clk); #1;
    @(negedge clk); prog_end = '0;
  endtask

  task automatic arm(input logic [3:0] m, input string req);
    put(m, 17'h05555, rep(8'hAA), m, req);
    put(m, 17'h02AAA, rep(8'h55), m, req);
    put(m, 17'h05555, rep(8'hA0), m, req);
  endtask

  task automatic release_seq(input logic [3:0] m, input string req);
    put(m, 17'h05555, rep(8'hAA), m, req);
    put(m, 17'h02AAA, rep(8'h55), m, req);
    put(m, 17'h05555, rep(8'h80), m, req);
    put(m, 17'h05555, rep(8'hAA), m, req);
    put(m, 17'h02AAA, rep(8'h55), m, req);
    put(m, 17'h05555, rep(8'h20), m, req);
  endtask

  task automatic t_reset;
    chk("R1 start lock", {28'd0, wp_on}, 32'h0);
    chk("R6 start permit", {28'd0, page_ok}, 32'hF);
    chk("R2 idle cmd", {28'd0, cmd_byte}, 32'h0);
  endtask

  task automatic t_arm_lane0;
    arm(4'h1, "R2 arm bytes");
    put(4'h1, 17'h00100, rep(8'h12), 4'h0, "R7 data after arm");
    chk("R4 lock waits", {28'd0, wp_on}, 32'h0);
    pend(4'h1);
    chk("R2 lock set", {28'd0, wp_on}, 32'h1);
    chk("R11 page closed", {28'd0, page_ok}, 32'hE);
  endtask

  task automatic t_locked_plain;
    put(4'h1, 17'h00200, rep(8'h34), 4'h0, "R5 plain byte");
    chk("R5 plain page refused", {28'd0, page_ok}, 32'hE);
    pend(4'h1);
    chk("R5 lock kept", {28'd0, wp_on}, 32'h1);
  endtask

  task automatic t_arm_nodata;
    arm(4'h4, "R2 arm lane2");
    pend(4'h4);
    chk("R2 lock without data", {28'd0, wp_on}, 32'h5);
    chk("R11 permit lane2", {28'd0, page_ok}, 32'hA);
  endtask

  task automatic t_locked_prefixed;
    arm(4'h1, "R5 prefix");
    chk("R5 prefixed page ok", {28'd0, page_ok}, 32'hB);
    put(4'h1, 17'h00210, rep(8'h9C), 4'h0, "R5 data");
    pend(4'h1);
    chk("R5 lock after prefixed", {28'd0, wp_on}, 32'h5);
    chk("R11 close again", {28'd0, page_ok}, 32'hA);
  endtask

  task automatic t_break;
    put(4'h1, 17'h05555, rep(8'hAA), 4'h1, "R7 lead");
    put(4'h1, 17'h02AAA, rep(8'h33), 4'h0, "R7 breaker");
    put(4'h1, 17'h05555, rep(8'hAA), 4'h0, "R8 late lead");
    put(4'h1, 17'h02AAA, rep(8'h55), 4'h0, "R8 late pair");
    put(4'h1, 17'h05555, rep(8'hA0), 4'h0, "R8 late lock");
    chk("R8 page stays refused", {28'd0, page_ok}, 32'hA);
    pend(4'h1);
    chk("R8 lock kept", {28'd0, wp_on}, 32'h5);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lock survives rst", {28'd0, wp_on}, 32'h5);
    chk("R1 permit after rst", {28'd0, page_ok}, 32'hA);
  endtask

  task automatic t_collide;
    @(negedge clk); wr_stb = 4'h1; wr_addr = 17'h05555; wr_data = rep(8'hAA); prog_end = 4'h1;
    @(posedge clk); #1;
    chk("R10 collided cmd", {28'd0, cmd_byte}, 32'h0);
    @(negedge clk); wr_stb = '0; prog_end = '0;
    put(4'h1, 17'h02AAA, rep(8'h55), 4'h0, "R10 lead was dropped");
    chk("R10 lock unchanged", {28'd0, wp_on}, 32'h5);
    pend(4'h1);
  endtask

  task automatic t_release_lane2;
    release_seq(4'h4, "R3 release lane2");
    chk("R4 release waits", {28'd0, wp_on}, 32'h5);
    pend(4'h4);
    chk("R3 lane2 released", {28'd0, wp_on}, 32'h1);
    chk("R11 lane2 open", {28'd0, page_ok}, 32'hE);
  endtask

  task automatic t_release_lane0;
    release_seq(4'h1, "R3 release lane0");
    put(4'h1, 17'h00300, rep(8'h56), 4'h0, "R3 data after release");
    chk("R3 data permitted", {28'd0, page_ok}, 32'hF);
    pend(4'h1);
    chk("R3 all released", {28'd0, wp_on}, 32'h0);
    put(4'h2, 17'h00400, rep(8'h77), 4'h0, "R6 data");
    chk("R6 open permit", {28'd0, page_ok}, 32'hF);
    pend(4'h2);
  endtask

  task automatic t_lanes;
    put(4'hF, 17'h05555, 32'hAAAA00AA, 4'hD, "R9 mixed lead");
    put(4'hF, 17'h02AAA, rep(8'h55), 4'hD, "R9 per-lane state");
    pend(4'hF);
    chk("R9 no lock", {28'd0, wp_on}, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_arm_lane0;
    t_locked_plain;
    t_arm_nodata;
    t_locked_prefixed;
    t_break;
    t_reset_keeps;
    t_collide;
    t_release_lane2;
    t_release_lane0;
    t_lanes;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule